// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Sequencer

This block is a synchronous model of the control side of a byte-wide paged nonvolatile memory that presents an SRAM-like interface. It has active-low chip enable, output enable and write enable, an address bus and a data bus. A host reads stored bytes as it would from a static RAM. A write collects bytes of a single page into a page buffer, and a per-byte mask records which bytes were loaded. Each accepted byte restarts a load window. When that window runs out, the buffer closes and a timed programming period commits only the loaded bytes to the storage array.

From the first accepted byte until programming ends, the block reports busy. While it is busy, a read returns a status byte in place of stored data. The top bit of the status byte is the complement of the last byte written. The next bit flips on every new read access. A host can therefore poll for completion with either bit. The load window and the programming time are both given as clock-cycle parameters. The address width is also a parameter. A full 32768-byte part uses an address width of 15. The default is smaller so that the array stays small at elaboration.

Top module: `pnv_page_seq`

## Requirements
- R1: With chip enable and output enable low and write enable high, while not busy, the byte stored at `addr_i` appears on `data_o` one clock after the address is presented, and `data_oe_o` is high.
- R2: `data_oe_o` is low whenever chip enable or output enable is high.
- R3: A write access exists while chip enable and write enable are low and output enable is high. Either write enable or chip enable may start and end it. The address is captured in the first clock of the access. The data is taken from the last clock of the access.
- R4: Address bits [ADDR_W-1:6] select the page and bits [5:0] select the byte within it. A write whose page differs from the page of the first byte in the current load is ignored.
- R5: Bytes may be loaded in any order, and a later write to the same byte replaces the earlier one. Array bytes of the page that were not loaded keep their old contents.
- R6: A byte accepted within LOAD_WIN clocks of the previous accepted byte joins the same load. After LOAD_WIN clocks with no accepted byte, programming begins.
- R7: Programming lasts PROG_CYCLES clocks, so busy stays high for LOAD_WIN + PROG_CYCLES clocks after the last accepted byte.
- R8: Writes attempted during programming are ignored and leave the array unchanged.
- R9: While busy, a read returns a status byte. Bit 7 is the inverse of bit 7 of the last accepted byte. Bit 6 inverts at the start of each read access. Bits 5 to 0 are zero.
- R10: `busy_o` rises on the first accepted byte and stays high until programming completes. The load mask is empty when busy falls.
- R11: Reset clears busy, the buffer, the mask and both timers, and leaves array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address; upper bits select the page |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data, or the status byte while busy |
| data_oe_o | output | 1 | Output drive enable for an external tristate |
| busy_o | output | 1 | Load or programming in progress |

## Verification
The bench loads a page in shuffled order, overwrites one byte, and ends accesses with both the write enable pulse and the chip enable pulse. If a design latched the data at the start of an access, or committed stale buffer slots, the array would hold wrong or overwritten neighbour bytes. It sends a write to a foreign page during a load and a write during programming. It then reads back bytes that were programmed earlier, which catches a design that merges such writes. It measures busy duration against the window and the programming time, spaces two bytes just inside the window, and reads the status byte twice. This exposes a missing complement or a toggle that does not move. A reset issued in mid-load must leave earlier array data readable.

// File: rtl/pnv_pkg.sv
package pnv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_st_e;
endpackage

// File: rtl/pnv_bus_if.sv
module pnv_bus_if #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_act_o,
  output logic              rd_start_o
);
  logic wr_act, wr_act_q, rd_act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign wr_act   = !ce_ni && !we_ni && oe_ni;
  assign rd_act_o = !ce_ni && !oe_ni && we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act_o;
      // address at the later falling enable, data tracked until the first rising one
      if (wr_act && !wr_act_q) addr_q <= addr_i;
      if (wr_act) data_q <= data_i;
    end
  end

  assign wr_stb_o   = wr_act_q && !wr_act;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;
  assign rd_start_o = rd_act_o && !rd_act_q;

  AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> !rd_act_o); // R2
endmodule

// File: rtl/pnv_page_buf.sv
module pnv_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int PAGE_W     = 5,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [OFS_W-1:0]  wr_ofs_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_en_i,
  input  logic              prog_i,
  input  logic              clr_i,
  input  logic [OFS_W-1:0]  cm_idx_i,
  output logic              accept_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [PAGE_BYTES-1:0] mask_o,
  output logic [DATA_W-1:0] cm_data_o,
  output logic              cm_valid_o
);
  logic [DATA_W-1:0]     byte_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [PAGE_W-1:0]     page_q;
  logic                  any_valid;

  assign any_valid = |valid_q;
  assign accept_o  = wr_stb_i && load_en_i && (!any_valid || (wr_page_i == page_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      page_q  <= '0;
    end else if (clr_i) begin
      valid_q <= '0;
    end else if (accept_o) begin
      valid_q[wr_ofs_i] <= 1'b1;
      if (!any_valid) page_q <= wr_page_i;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q[g] <= '0;
      else if (accept_o && (wr_ofs_i == OFS_W'(g))) byte_q[g] <= wr_data_i;
    end
  end

  assign page_o     = page_q;
  assign mask_o     = valid_q;
  assign cm_data_o  = byte_q[cm_idx_i];
  assign cm_valid_o = valid_q[cm_idx_i];

  AST_PAGE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_valid && $past(any_valid)) |-> $stable(page_q)); // R4
  AST_MASK_FROZEN_IN_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && $past(prog_i)) |-> $stable(valid_q)); // R8
endmodule

// File: rtl/pnv_prog_ctrl.sv
module pnv_prog_ctrl
  import pnv_pkg::*;
#(
  parameter int LOAD_WIN    = 18750,
  parameter int PROG_CYCLES = 1250000,
  parameter int PAGE_BYTES  = 64,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int WIN_W      = $clog2(LOAD_WIN + 1),
  localparam int PRG_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  output logic             busy_o,
  output logic             load_en_o,
  output logic             prog_o,
  output logic             clr_o,
  output logic             cm_en_o,
  output logic [OFS_W-1:0] cm_idx_o
);
  seq_st_e          st_q;
  logic [WIN_W-1:0] win_q;
  logic [PRG_W-1:0] prg_q;
  logic             prg_last;

  assign prg_last = (prg_q == PRG_W'(PROG_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      win_q <= '0;
      prg_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_i) begin
          st_q  <= ST_LOAD;
          win_q <= '0;
        end
        ST_LOAD: begin
          if (accept_i) win_q <= '0;
          else if (win_q == WIN_W'(LOAD_WIN - 1)) begin
            st_q  <= ST_PROG;
            win_q <= '0;
            prg_q <= '0;
          end else win_q <= win_q + 1'b1;
        end
        ST_PROG: begin
          if (prg_last) st_q <= ST_IDLE;
          else prg_q <= prg_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign prog_o    = (st_q == ST_PROG);
  assign load_en_o = !prog_o;
  assign clr_o     = prog_o && prg_last;
  // one buffer slot per cycle at the start of programming
  assign cm_en_o   = prog_o && (prg_q < PRG_W'(PAGE_BYTES));
  assign cm_idx_o  = prg_q[OFS_W-1:0];

  initial begin
    assert (PROG_CYCLES > PAGE_BYTES);
    assert (LOAD_WIN > 1);
  end

  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q < WIN_W'(LOAD_WIN)); // R6
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_o && !prg_last) |=> busy_o); // R10
  AST_LOAD_TO_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && !accept_i && win_q == WIN_W'(LOAD_WIN - 1)) |=> prog_o); // R6
endmodule

// File: rtl/pnv_array.sv
module pnv_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pnv_page_seq.sv
module pnv_page_seq #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int LOAD_WIN    = 18750,
  parameter int PROG_CYCLES = 1250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic              wr_stb, rd_act, rd_start;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              accept, load_en, prog, clr, cm_en, cm_valid;
  logic [OFS_W-1:0]  cm_idx;
  logic [PAGE_W-1:0] page;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0] cm_data, rd_data, last_q, status;
  logic              tgl_q;

  pnv_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_act_o(rd_act), .rd_start_o(rd_start)
  );

  pnv_page_buf #(.PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .wr_page_i(wr_addr[ADDR_W-1:OFS_W]), .wr_ofs_i(wr_addr[OFS_W-1:0]),
    .wr_data_i(wr_data), .load_en_i(load_en), .prog_i(prog), .clr_i(clr),
    .cm_idx_i(cm_idx), .accept_o(accept), .page_o(page), .mask_o(mask),
    .cm_data_o(cm_data), .cm_valid_o(cm_valid)
  );

  pnv_prog_ctrl #(.LOAD_WIN(LOAD_WIN), .PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .accept_i(accept), .busy_o, .load_en_o(load_en), .prog_o(prog),
    .clr_o(clr), .cm_en_o(cm_en), .cm_idx_o(cm_idx)
  );

  pnv_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk_i, .we_i(cm_en && cm_valid), .waddr_i({page, cm_idx}), .wdata_i(cm_data),
    .raddr_i(addr_i), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      if (accept) last_q <= wr_data;
      if (busy_o && rd_start) tgl_q <= !tgl_q;
    end
  end

  always_comb begin
    status = '0;
    status[DATA_W-1] = !last_q[DATA_W-1];
    status[DATA_W-2] = tgl_q;
  end

  assign data_o    = busy_o ? status : rd_data;
  assign data_oe_o = rd_act;

  AST_MASK_EMPTY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (mask == '0)); // R10
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o); // R10
  AST_NO_ACCEPT_IN_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog |-> !accept); // R8
endmodule

// File: tb/sim_pnv_page_seq.sv
module sim_pnv_page_seq;
  localparam int AW = 11;
  localparam int LW = 40;
  localparam int PC = 200;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0, data_o;
  logic data_oe_o, busy_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  byte unsigned exp_q[$], msk_q[$];
  string tag_q[$];
  event smp_ev;

  always #4 clk = ~clk;

  pnv_page_seq #(.ADDR_W(AW), .LOAD_WIN(LW), .PROG_CYCLES(PC)) u0 (
    .clk_i(clk), .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .data_o, .data_oe_o, .busy_o
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(smp_ev);
    while (exp_q.size() > 0) begin
      automatic byte unsigned e = exp_q.pop_front();
      automatic byte unsigned m = msk_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk((data_o & m) == (e & m), t, int'(data_o & m), int'(e & m));
    end
  end

  task automatic write_byte(logic [AW-1:0] a, logic [7:0] d, bit via_ce);
    @(negedge clk);
    addr_i = a; data_i = d; oe_ni = 1'b1;
    if (via_ce) begin we_ni = 1'b0; @(negedge clk); ce_ni = 1'b0; end
    else begin ce_ni = 1'b0; @(negedge clk); we_ni = 1'b0; end
    repeat (2) @(negedge clk);
    if (via_ce) ce_ni = 1'b1; else we_ni = 1'b1;
    @(negedge clk);
    ce_ni = 1'b1; we_ni = 1'b1;
  endtask

  task automatic read_exp(logic [AW-1:0] a, byte unsigned e, byte unsigned m, string t);
    @(negedge clk);
    addr_i = a; ce_ni = 1'b0; oe_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(data_oe_o == 1'b1, "R1", int'(data_oe_o), 1);
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
    -> smp_ev;
    @(negedge clk);
    ce_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic read_raw(logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr_i = a; ce_ni = 1'b0; oe_ni = 1'b0;
    repeat (2) @(negedge clk);
    v = data_o;
    @(negedge clk);
    ce_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    logic [7:0] v1, v2;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R11", int'(busy_o), 0);
    chk(data_oe_o == 1'b0, "R11", int'(data_oe_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // seed contents
    write_byte(11'h084, 8'h11, 1'b0); wait_idle(n);
    write_byte(11'h0C3, 8'h99, 1'b0); wait_idle(n);
    write_byte(11'h100, 8'h01, 1'b1);
    write_byte(11'h101, 8'h55, 1'b1); wait_idle(n);
    read_exp(11'h084, 8'h11, 8'hFF, "R1");

    // shuffled load with overwrite and a foreign-page write
    write_byte(11'h085, 8'hA5, 1'b0);
    chk(busy_o == 1'b1, "R10", int'(busy_o), 1);
    write_byte(11'h083, 8'h3C, 1'b1);
    write_byte(11'h085, 8'h5A, 1'b0);
    write_byte(11'h0C3, 8'h77, 1'b0);
    read_raw(11'h085, v1);
    read_raw(11'h085, v2);
    chk(v1[7] == 1'b1, "R9", int'(v1[7]), 1);
    chk(v1[6] != v2[6], "R9", int'(v2[6]), int'(!v1[6]));
    chk(v1[5:0] == 6'd0, "R9", int'(v1[5:0]), 0);
    wait_idle(n);
    chk(busy_o == 1'b0, "R10", int'(busy_o), 0);
    read_exp(11'h085, 8'h5A, 8'hFF, "R5");
    read_exp(11'h083, 8'h3C, 8'hFF, "R3");
    read_exp(11'h084, 8'h11, 8'hFF, "R5");
    read_exp(11'h0C3, 8'h99, 8'hFF, "R4");

    // busy duration, plus status complement for a byte with bit 7 set
    write_byte(11'h200, 8'hE6, 1'b0);
    read_exp(11'h000, 8'h00, 8'hBF, "R9");
    wait_idle(n);
    chk(n >= LW + PC - 10 && n <= LW + PC + 2, "R7", n, LW + PC);
    read_exp(11'h200, 8'hE6, 8'hFF, "R7");

    // window expiry, then a write during programming
    write_byte(11'h100, 8'h42, 1'b0);
    repeat (LW + 20) @(negedge clk);
    write_byte(11'h101, 8'hEE, 1'b0);
    wait_idle(n);
    read_exp(11'h100, 8'h42, 8'hFF, "R6");
    read_exp(11'h101, 8'h55, 8'hFF, "R8");

    // two bytes spaced inside the window form one load
    write_byte(11'h140, 8'hC1, 1'b1);
    repeat (LW - 10) @(negedge clk);
    write_byte(11'h141, 8'hC2, 1'b0);
    wait_idle(n);
    chk(n >= LW + PC - 10 && n <= LW + PC + 2, "R6", n, LW + PC);
    read_exp(11'h140, 8'hC1, 8'hFF, "R6");
    read_exp(11'h141, 8'hC2, 8'hFF, "R6");

    // output enable gating
    @(negedge clk); ce_ni = 1'b0; oe_ni = 1'b1;
    @(negedge clk); chk(data_oe_o == 1'b0, "R2", int'(data_oe_o), 0);
    ce_ni = 1'b1; oe_ni = 1'b0;
    @(negedge clk); chk(data_oe_o == 1'b0, "R2", int'(data_oe_o), 0);
    oe_ni = 1'b1;

    // reset in mid-load keeps the array
    write_byte(11'h086, 8'hAB, 1'b0);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0, "R11", int'(busy_o), 0);
    rst_ni = 1'b1;
    read_exp(11'h085, 8'h5A, 8'hFF, "R11");
    read_exp(11'h141, 8'hC2, 8'hFF, "R11");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule